// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the hardware part of entering an exception. When a request with a vector number is accepted, it takes a snapshot of the status word, the return PC and the stack pointer. It writes the status word and then the PC onto a stack that grows downward. It then reads the handler address from a table located by a vector base register and hands the fetched value to the core as the new PC. All memory traffic uses one word-wide port. Each transfer is held until the memory answers ready.

Alignment is checked during stacking but never stops it. A stack pointer that is not word aligned still produces both stack writes. Those writes go out with the two low address bits forced to zero, and the pointer is decremented by exactly four per push. A vector base that is not word aligned is flagged the same way. Either fault sets a single pending flag. That flag starts an address-error entry as soon as the current entry has finished. Faults seen while that address-error entry is itself stacking are dropped, so entry cannot repeat without end.

Top module: `exc_entry_seq`

## Requirements
- R1: After acceptance with entry stack pointer S, the first bus transfer writes the latched status word to address (S-4) with bits [1:0] forced to 0. The second writes the latched return PC to (S-8), also with bits [1:0] forced to 0. Both are writes (memWe=1).
- R2: When the new PC is loaded, spOut equals the entry stack pointer minus 8, with its low bits unchanged. A misaligned pointer stays misaligned.
- R3: The third transfer is a read (memWe=0) at (vbrIn + 4*vector) with bits [1:0] forced to 0. The returned word appears on pcOut. pcLoad pulses for one cycle in the cycle after the read completes.
- R4: A misaligned stack pointer does not cancel stacking. All three transfers of the entry still take place.
- R5: If the stack pointer (bits [1:0] nonzero) or vbrIn is misaligned during a normal entry, an address-error entry with vector ADDR_ERR_VEC (default 9) starts after that entry's pcLoad. Its stack pointer continues from spOut. It pushes srIn and the handler PC that was just loaded.
- R6: Misalignment seen during an address-error entry raises no further entry. After its pcLoad the block goes idle.
- R7: reqAccept is asserted only while the block is idle. A request held during an entry is accepted only after that entry completes. A pending address error is served before a waiting request.
- R8: busy is high from the cycle after acceptance through the pcLoad cycle, and low in the cycle after pcLoad. While memReq is high and memReady is low, memReq, memAddr and memWe hold their values.
- R9: During and right after reset, busy, memReq and pcLoad are low, and spOut and pcOut are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception request present, held until accepted |
| reqVec | input | 8 | Vector number of the request |
| reqAccept | output | 1 | Request taken this cycle |
| spIn | input | 32 | Stack pointer at request time |
| srIn | input | 32 | Status word to be stacked |
| pcIn | input | 32 | Return PC to be stacked |
| vbrIn | input | 32 | Vector table base |
| memReq | output | 1 | Bus transfer requested |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word address, bits [1:0] always 0 |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Transfer completes this cycle |
| busy | output | 1 | Entry in progress |
| pcLoad | output | 1 | One-cycle strobe: pcOut holds the new PC |
| pcOut | output | 32 | Loaded handler PC |
| spOut | output | 32 | Stack pointer after stacking |

## Verification
Some internal faults show up at the ports within one entry: a wrong pointer step, a missed latch or a lost vector. They appear as a wrong address or data in the stack writes, or as a wrong spOut at the next pcLoad. A pending flag that is set or cleared wrongly is visible one idle cycle after pcLoad. It appears either as an address-error entry that never comes, or as one more stack write that should not happen. A wrongly suppressed fault during an address-error entry appears the same way. Requests held across an entry, with random memory wait states, expose ordering faults through the sequence of accepted vectors.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_SR, ST_PUSH_PC, ST_FETCH_VEC, ST_LOAD_PC
  } seqState_t;

  typedef enum logic [1:0] {BUS_SR, BUS_PC, BUS_VEC} busSel_t;

  typedef struct packed {
    logic    acceptReq;
    logic    startAe;
    logic    stepSp;
    logic    chkSp;
    logic    chkVbr;
    logic    latchPc;
    busSel_t busSel;
  } seqStrobe_t;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       aePending,
  input  logic       memReady,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       reqAccept,
  output logic       pcLoad,
  output logic       busy
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.busSel = BUS_SR;
    memReq    = 1'b0;
    memWe     = 1'b0;
    reqAccept = 1'b0;
    pcLoad    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (aePending) begin
          strb.startAe = 1'b1;
          nextState    = ST_PUSH_SR;
        end else if (reqValid) begin
          strb.acceptReq = 1'b1;
          reqAccept      = 1'b1;
          nextState      = ST_PUSH_SR;
        end
      end
      ST_PUSH_SR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strb.busSel = BUS_SR;
        if (memReady) begin
          strb.chkSp  = 1'b1;
          strb.stepSp = 1'b1;
          nextState   = ST_PUSH_PC;
        end
      end
      ST_PUSH_PC: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strb.busSel = BUS_PC;
        if (memReady) begin
          strb.chkSp = 1'b1;
          nextState  = ST_FETCH_VEC;
        end
      end
      ST_FETCH_VEC: begin
        memReq = 1'b1;
        strb.busSel = BUS_VEC;
        if (memReady) begin
          strb.latchPc = 1'b1;
          strb.chkVbr  = 1'b1;
          nextState    = ST_LOAD_PC;
        end
      end
      ST_LOAD_PC: begin
        pcLoad    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int DW           = 32,
  parameter int VW           = 8,
  parameter int ADDR_ERR_VEC = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  input  logic [DW-1:0] spIn,
  input  logic [DW-1:0] srIn,
  input  logic [DW-1:0] pcIn,
  input  logic [DW-1:0] vbrIn,
  input  logic [VW-1:0] reqVec,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] pcOut,
  output logic          aePending
);
  localparam int          PAD  = DW - VW - 2;
  localparam logic [DW-1:0] STEP = DW'(4);
  localparam logic [VW-1:0] AE_V = VW'(ADDR_ERR_VEC);

  logic [DW-1:0] spReg, srSave, pcSave, pcReg;
  logic [VW-1:0] vecReg;
  logic          inAe, pendReg;
  logic [DW-1:0] vecAddr, stackAddr;
  logic          spMis, vbrMis;

  assign spMis     = |spReg[1:0];
  assign vbrMis    = |vbrIn[1:0];
  assign vecAddr   = vbrIn + {{PAD{1'b0}}, vecReg, 2'b00};
  assign stackAddr = {spReg[DW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg   <= '0;
      srSave  <= '0;
      pcSave  <= '0;
      pcReg   <= '0;
      vecReg  <= '0;
      inAe    <= 1'b0;
      pendReg <= 1'b0;
    end else begin
      if (strb.acceptReq) begin
        spReg  <= spIn - STEP;
        srSave <= srIn;
        pcSave <= pcIn;
        vecReg <= reqVec;
        inAe   <= 1'b0;
      end
      if (strb.startAe) begin
        spReg   <= spReg - STEP;
        srSave  <= srIn;
        pcSave  <= pcReg;
        vecReg  <= AE_V;
        inAe    <= 1'b1;
        pendReg <= 1'b0;
      end
      if (strb.stepSp) spReg <= spReg - STEP;
      if (strb.chkSp && spMis && !inAe) pendReg <= 1'b1;
      if (strb.chkVbr && vbrMis && !inAe) pendReg <= 1'b1;
      if (strb.latchPc) pcReg <= memRdata;
    end
  end

  always_comb begin
    unique case (strb.busSel)
      BUS_SR:  begin memAddr = stackAddr; memWdata = srSave; end
      BUS_PC:  begin memAddr = stackAddr; memWdata = pcSave; end
      default: begin memAddr = {vecAddr[DW-1:2], 2'b00}; memWdata = '0; end
    endcase
  end

  assign spOut     = spReg;
  assign pcOut     = pcReg;
  assign aePending = pendReg;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int DW           = 32,
  parameter int VW           = 8,
  parameter int ADDR_ERR_VEC = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [VW-1:0] reqVec,
  output logic          reqAccept,
  input  logic [DW-1:0] spIn,
  input  logic [DW-1:0] srIn,
  input  logic [DW-1:0] pcIn,
  input  logic [DW-1:0] vbrIn,
  output logic          memReq,
  output logic          memWe,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memReady,
  output logic          busy,
  output logic          pcLoad,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] spOut
);
  seqStrobe_t strb;
  logic       aePending;

  exc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .aePending(aePending),
    .memReady(memReady), .strb(strb), .memReq(memReq), .memWe(memWe),
    .reqAccept(reqAccept), .pcLoad(pcLoad), .busy(busy)
  );

  exc_seq_dp #(.DW(DW), .VW(VW), .ADDR_ERR_VEC(ADDR_ERR_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .spIn(spIn), .srIn(srIn),
    .pcIn(pcIn), .vbrIn(vbrIn), .reqVec(reqVec), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .spOut(spOut), .pcOut(pcOut),
    .aePending(aePending)
  );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqAccept,
  input logic          memReq,
  input logic          memWe,
  input logic [DW-1:0] memAddr,
  input logic          memReady,
  input logic          busy,
  input logic          pcLoad
);
  // R1
  bus_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> !busy);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> busy);

  // R8
  idle_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);

  // R3
  load_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $past(memReq && !memWe && memReady));

  // R8
  req_inside_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || pcLoad) |-> busy);
endmodule

bind exc_entry_seq exc_seq_chk #(.DW(DW)) u_seq_chk (
  .clk(clk), .rstN(rstN), .reqAccept(reqAccept), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .memReady(memReady), .busy(busy),
  .pcLoad(pcLoad)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  localparam int AEV = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVec = '0;
  logic        reqAccept;
  logic [31:0] spIn = '0, srIn = '0, pcIn = '0, vbrIn = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;
  logic        busy, pcLoad;
  logic [31:0] pcOut, spOut;

  always #2 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVec),
    .reqAccept(reqAccept), .spIn(spIn), .srIn(srIn), .pcIn(pcIn),
    .vbrIn(vbrIn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .pcLoad(pcLoad), .pcOut(pcOut), .spOut(spOut)
  );

  int nChk = 0, nErr = 0;
  logic        logWe[1024];
  logic [31:0] logAddr[1024], logData[1024];
  int nLog = 0, logPtr = 0;
  logic [31:0] ldPc[512], ldSp[512];
  int nLd = 0, ldPtr = 0;
  logic [7:0]  accVec[512];
  int nAcc = 0, badAcc = 0, waitLeft = 0;

  function automatic logic [31:0] rdFn(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 1'b0;
      waitLeft = 0;
    end else begin
      if (pcLoad && nLd < 512) begin
        ldPc[nLd] = pcOut; ldSp[nLd] = spOut; nLd++;
      end
      if (reqAccept) begin
        if (busy) badAcc++;
        if (nAcc < 512) begin accVec[nAcc] = reqVec; nAcc++; end
      end
      memReady = 1'b0;
      if (memReq) begin
        if (waitLeft == 0) begin
          memReady = 1'b1;
          memRdata = rdFn(memAddr);
          if (nLog < 1024) begin
            logWe[nLog] = memWe; logAddr[nLog] = memAddr; logData[nLog] = memWdata;
            nLog++;
          end
          waitLeft = $urandom % 3;
        end else waitLeft--;
      end
    end
  end

  task automatic expectEntry(input logic [31:0] sp, input logic [31:0] sr,
                             input logic [31:0] pc, input logic [31:0] vbr,
                             input logic [7:0] vec, output logic [31:0] newPc);
    logic [31:0] va;
    va = (vbr + {22'd0, vec, 2'b00}) & ~32'd3;
    newPc = rdFn(va);
    check("R1 sr write kind", 32'(logWe[logPtr]), 32'd1);
    check("R1 sr addr", logAddr[logPtr], (sp - 32'd4) & ~32'd3);
    check("R1 sr data", logData[logPtr], sr);
    check("R4 pc write kind", 32'(logWe[logPtr+1]), 32'd1);
    check("R1 pc addr", logAddr[logPtr+1], (sp - 32'd8) & ~32'd3);
    check("R1 pc data", logData[logPtr+1], pc);
    check("R3 vec read kind", 32'(logWe[logPtr+2]), 32'd0);
    check("R3 vec addr", logAddr[logPtr+2], va);
    check("R3 pcOut", ldPc[ldPtr], newPc);
    check("R2 spOut", ldSp[ldPtr], sp - 32'd8);
    logPtr += 3;
    ldPtr++;
  endtask

  task automatic waitIdle;
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(posedge clk); #1;
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic runTrial(input logic [31:0] sp, input logic [31:0] sr,
                          input logic [31:0] pc, input logic [31:0] vbr,
                          input logic [7:0] vec);
    logic [31:0] np, np2;
    spIn = sp; srIn = sr; pcIn = pc; vbrIn = vbr; reqVec = vec;
    reqValid = 1'b1;
    do begin @(posedge clk); #1; end while (!busy);
    reqValid = 1'b0;
    waitIdle();
    expectEntry(sp, sr, pc, vbr, vec, np);
    if ((sp[1:0] != 2'b00) || (vbr[1:0] != 2'b00))
      expectEntry(sp - 32'd8, sr, np, vbr, 8'(AEV), np2); // R5
    check("R6 no extra traffic", 32'(nLog), 32'(logPtr));
    check("R6 no extra load", 32'(nLd), 32'(ldPtr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] np, np2, sp, vbr;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R9 busy in reset", 32'(busy), 32'd0);
    check("R9 memReq in reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 busy", 32'(busy), 32'd0);
    check("R9 memReq", 32'(memReq), 32'd0);
    check("R9 pcLoad", 32'(pcLoad), 32'd0);
    check("R9 spOut", spOut, 32'd0);
    check("R9 pcOut", pcOut, 32'd0);

    // directed: aligned, misaligned SP, misaligned VBR, both
    runTrial(32'h0000_8000, 32'h0000_00F0, 32'h1234_5670, 32'h0000_1000, 8'd4);
    runTrial(32'h0000_8002, 32'h0000_0011, 32'h2000_0010, 32'h0000_1000, 8'd11);
    runTrial(32'h0000_9000, 32'h0000_0022, 32'h3000_0020, 32'h0000_2001, 8'd200);
    runTrial(32'h0000_A003, 32'h0000_0033, 32'h4000_0030, 32'h0000_3003, 8'd255);

    // directed: request held through an entry that raises an address error (R7)
    spIn = 32'h0000_4001; srIn = 32'h55; pcIn = 32'h0000_0100;
    vbrIn = 32'h0000_0400; reqVec = 8'd7; reqValid = 1'b1;
    do begin @(posedge clk); #1; end while (!busy);
    spIn = 32'h0000_6000; pcIn = 32'h0000_0200; reqVec = 8'd20;
    while (nAcc < 6) begin @(posedge clk); #1; end
    reqValid = 1'b0;
    waitIdle();
    expectEntry(32'h0000_4001, 32'h55, 32'h0000_0100, 32'h0000_0400, 8'd7, np);
    expectEntry(32'h0000_3FF9, 32'h55, np, 32'h0000_0400, 8'(AEV), np2);
    expectEntry(32'h0000_6000, 32'h55, 32'h0000_0200, 32'h0000_0400, 8'd20, np);
    check("R7 first accepted vec", 32'(accVec[4]), 32'd7);
    check("R7 held vec accepted later", 32'(accVec[5]), 32'd20);
    check("R7 accept while busy", 32'(badAcc), 32'd0);
    check("R6 traffic count", 32'(nLog), 32'(logPtr));

    // random trials
    for (int t = 0; t < 40; t++) begin
      sp  = $urandom & ~32'd3;
      vbr = $urandom & 32'h00FF_FFFC;
      if ($urandom % 4 == 0) sp  = sp  | ($urandom % 4);
      if ($urandom % 6 == 0) vbr = vbr | ($urandom % 4);
      runTrial(sp, $urandom, $urandom, vbr, 8'($urandom));
    end
    check("R7 accept while busy final", 32'(badAcc), 32'd0);
    summary();
  end
endmodule